// File: doc/BRIEF.md
# Exclusive Access Monitor

This block observes the address-phase requests presented to a shared memory-mapped slave and decides the outcome of exclusive read-modify-write sequences issued by several masters. An exclusive read arms a tracking entry for the issuing ID over the granules its burst covers. A later exclusive write from that ID wins only if its address, size and length match the armed entry and no other master has written into the tracked granules since. A winning write returns the exclusive-okay code. A losing write returns plain okay and raises a suppress flag so the memory keeps its old contents. The master then retries.

Requests enter on a valid/ready stream, one per cycle. Each accepted request produces exactly one registered response on a valid/ready output stream. The input is ready whenever the output register is empty or is being drained in the same cycle (`req_ready = !rsp_valid || rsp_ready`). While `rsp_valid` is high and `rsp_ready` is low, the response fields hold steady and no new request is taken. Reads by other masters never disturb an armed entry, and nothing is ever locked. Exclusive bursts longer than 16 beats are flagged as protocol errors. Normal bursts of any length pass without a flag.

Top module: `excl_access_monitor`

## Requirements
- R1: After synchronous active-low reset, `rsp_valid` is 0, `req_ready` is 1 and no entry is armed, so a first exclusive write fails.
- R2: An exclusive read with `req_len` of 15 or less returns `rsp_resp` 2'b01 (exclusive okay) with `rsp_err` 0, and arms the entry of its ID.
- R3: An exclusive write from an armed ID with identical address, `req_len` and `req_size`, and no intervening conflicting write, returns 2'b01 with `rsp_suppress` 0.
- R4: Reads of any kind by other IDs, and writes by other IDs into granules outside the armed range, leave the entry armed.
- R5: A normal write, or a winning exclusive write, by another ID that touches any armed granule clears that entry. The later exclusive write then returns 2'b00 with `rsp_suppress` 1.
- R6: An exclusive write whose address, size or length differs from its ID's armed entry fails (2'b00, suppress 1).
- R7: Every completed exclusive write, winning or losing, clears its own ID's entry, so a repeated write fails.
- R8: A new exclusive read from an ID replaces that ID's previous entry.
- R9: An exclusive request with `req_len` above 15 sets `rsp_err` and returns 2'b00. As a read it does not arm. As a write it is suppressed. A normal request with `req_len` above 15 has `rsp_err` 0.
- R10: Tracking granularity is 2^GRAN_LG bytes. A foreign write to a byte outside the exclusive burst but inside the same granule still clears the entry.
- R11: `req_ready` equals `!rsp_valid || rsp_ready`. During a stall all response fields hold.
- R12: Normal reads and writes return 2'b00 with `rsp_suppress` 0, and `rsp_id` echoes `req_id` on every response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_excl | input | 1 | Exclusive access |
| req_id | input | ID_W | Master ID, selects the entry |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | 8 | Beats minus one |
| req_size | input | 3 | log2 of bytes per beat |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed when high with rsp_valid |
| rsp_id | output | ID_W | ID of the answered request |
| rsp_resp | output | 2 | 2'b01 exclusive okay, 2'b00 okay |
| rsp_suppress | output | 1 | Failed exclusive write: do not update memory |
| rsp_err | output | 1 | Exclusive burst over 16 beats |

## Verification
The main function is tried with four kinds of traffic between an exclusive read and its write:
- A clean pair separates a working arm/compare path from one that never succeeds.
- Foreign reads, and foreign writes to a distant granule, separate correct monitoring from over-eager clearing.
- Foreign writes that touch the tracked granule, including a byte outside the burst but inside the granule, separate correct clearing from a monitor that ignores other masters or compares exact bytes.
- Same-ID writes with a shifted address or a changed length separate the full match from an ID-only check.

Separate runs cover re-arming, repeated writes, over-long bursts and a stalled output.

// File: rtl/exm_pkg.sv
package exm_pkg;
  localparam int LEN_W        = 8;
  localparam int SIZE_W       = 3;
  localparam int EXCL_MAX_LEN = 15;

  typedef enum logic [1:0] {
    RESP_OKAY   = 2'b00,
    RESP_EXOKAY = 2'b01
  } resp_e;
endpackage

// File: rtl/exm_span.sv
module exm_span
  import exm_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int GRAN_LG = 6,
  localparam int EXT_W  = ADDR_W + 16,
  localparam int GW     = EXT_W - GRAN_LG
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  input  logic [SIZE_W-1:0] size,
  output logic [GW-1:0]     first_g,
  output logic [GW-1:0]     last_g
);
  logic [EXT_W-1:0] lo_b;
  logic [EXT_W-1:0] hi_b;
  logic [EXT_W-1:0] bytes;

  always_comb begin
    lo_b    = EXT_W'(addr);
    bytes   = (EXT_W'(len) + EXT_W'(1)) << size;
    hi_b    = lo_b + bytes - EXT_W'(1);
    first_g = GW'(lo_b >> GRAN_LG);
    last_g  = GW'(hi_b >> GRAN_LG);
  end
endmodule

// File: rtl/exm_entry.sv
module exm_entry
  import exm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int GW     = 42
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              clr,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [SIZE_W-1:0] in_size,
  input  logic [GW-1:0]     in_first,
  input  logic [GW-1:0]     in_last,
  output logic              ent_vld,
  output logic [ADDR_W-1:0] ent_addr,
  output logic [LEN_W-1:0]  ent_len,
  output logic [SIZE_W-1:0] ent_size,
  output logic [GW-1:0]     ent_first,
  output logic [GW-1:0]     ent_last
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_vld   <= 1'b0;
      ent_addr  <= '0;
      ent_len   <= '0;
      ent_size  <= '0;
      ent_first <= '0;
      ent_last  <= '0;
    end else if (arm) begin
      ent_vld   <= 1'b1;
      ent_addr  <= in_addr;
      ent_len   <= in_len;
      ent_size  <= in_size;
      ent_first <= in_first;
      ent_last  <= in_last;
    end else if (clr) begin
      ent_vld <= 1'b0;
    end
  end

  AST_ARM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> ent_vld); // R2
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !arm) |=> !ent_vld); // R7
  AST_ARM_CLR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(arm && clr)); // R8
endmodule

// File: rtl/excl_access_monitor.sv
module excl_access_monitor
  import exm_pkg::*;
#(
  parameter int ID_W    = 2,
  parameter int ADDR_W  = 32,
  parameter int GRAN_LG = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_excl,
  input  logic [ID_W-1:0]   req_id,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_len,
  input  logic [2:0]        req_size,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ID_W-1:0]   rsp_id,
  output logic [1:0]        rsp_resp,
  output logic              rsp_suppress,
  output logic              rsp_err
);
  localparam int NUM_ENT = 1 << ID_W;
  localparam int EXT_W   = ADDR_W + 16;
  localparam int GW      = EXT_W - GRAN_LG;

  logic          acc;
  logic [GW-1:0] r_first, r_last;
  logic          proto_bad, own_match, wr_win, rd_arm, foreign_kill;

  logic [NUM_ENT-1:0] e_vld, e_arm, e_clr, e_hit;
  logic [ADDR_W-1:0]  e_addr  [NUM_ENT];
  logic [LEN_W-1:0]   e_len   [NUM_ENT];
  logic [SIZE_W-1:0]  e_size  [NUM_ENT];
  logic [GW-1:0]      e_first [NUM_ENT];
  logic [GW-1:0]      e_last  [NUM_ENT];

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;

  exm_span #(.ADDR_W(ADDR_W), .GRAN_LG(GRAN_LG)) u_span (
    .addr(req_addr), .len(req_len), .size(req_size),
    .first_g(r_first), .last_g(r_last)
  );

  always_comb begin
    proto_bad    = req_excl && (req_len > LEN_W'(EXCL_MAX_LEN));
    own_match    = e_vld[req_id] && (e_addr[req_id] == req_addr) &&
                   (e_len[req_id] == req_len) && (e_size[req_id] == req_size);
    wr_win       = req_write && req_excl && !proto_bad && own_match;
    rd_arm       = !req_write && req_excl && !proto_bad;
    foreign_kill = req_write && (!req_excl || wr_win);
  end

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
    assign e_hit[i] = e_vld[i] && !((r_last < e_first[i]) || (r_first > e_last[i]));
    assign e_arm[i] = acc && rd_arm && (req_id == ID_W'(i));
    assign e_clr[i] = acc && req_write &&
                      ((req_excl && (req_id == ID_W'(i))) ||
                       (foreign_kill && (req_id != ID_W'(i)) && e_hit[i]));

    exm_entry #(.ADDR_W(ADDR_W), .GW(GW)) u_ent (
      .clk(clk), .rst_n(rst_n), .arm(e_arm[i]), .clr(e_clr[i]),
      .in_addr(req_addr), .in_len(req_len), .in_size(req_size),
      .in_first(r_first), .in_last(r_last),
      .ent_vld(e_vld[i]), .ent_addr(e_addr[i]), .ent_len(e_len[i]),
      .ent_size(e_size[i]), .ent_first(e_first[i]), .ent_last(e_last[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_id       <= '0;
      rsp_resp     <= RESP_OKAY;
      rsp_suppress <= 1'b0;
      rsp_err      <= 1'b0;
    end else if (req_ready) begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_id       <= req_id;
        rsp_resp     <= (rd_arm || wr_win) ? RESP_EXOKAY : RESP_OKAY;
        rsp_suppress <= req_write && req_excl && !wr_win;
        rsp_err      <= proto_bad;
      end
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_id) &&
      $stable(rsp_resp) && $stable(rsp_suppress) && $stable(rsp_err))); // R11
  AST_SUPPRESS_OKAY: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_suppress) |-> (rsp_resp == RESP_OKAY)); // R5
  AST_ERR_NO_EXOKAY: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_resp == RESP_OKAY)); // R9
  AST_ONE_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(e_arm)); // R8
endmodule

// File: tb/sim_excl_access_monitor.sv
module sim_excl_access_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_excl = 1'b0;
  logic [1:0]  req_id = '0;
  logic [31:0] req_addr = '0;
  logic [7:0]  req_len = '0;
  logic [2:0]  req_size = '0;
  logic        rsp_ready = 1'b1;
  logic        req_ready, rsp_valid, rsp_suppress, rsp_err;
  logic [1:0]  rsp_id, rsp_resp;
  int n_run = 0, n_fail = 0;

  excl_access_monitor u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_excl(req_excl), .req_id(req_id),
    .req_addr(req_addr), .req_len(req_len), .req_size(req_size),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_id(rsp_id),
    .rsp_resp(rsp_resp), .rsp_suppress(rsp_suppress), .rsp_err(rsp_err)
  );

  always #5 clk = ~clk;

  task automatic chk(string tag, int got, int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic xfer(logic w, logic x, logic [1:0] id, logic [31:0] a,
                      logic [7:0] l, logic [2:0] s);
    @(negedge clk);
    req_write = w; req_excl = x; req_id = id; req_addr = a;
    req_len = l; req_size = s; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_rsp(string tag, logic [1:0] id, int resp, int sup, int err);
    chk({tag, " valid"}, rsp_valid, 1);
    chk({tag, " id"}, rsp_id, id);
    chk({tag, " resp"}, rsp_resp, resp);
    chk({tag, " suppress"}, rsp_suppress, sup);
    chk({tag, " err"}, rsp_err, err);
  endtask

  task automatic t_reset();
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 req_ready", req_ready, 1);
    xfer(1, 1, 0, 32'h100, 0, 2);
    expect_rsp("R1 unarmed write", 0, 0, 1, 0);
  endtask

  task automatic t_basic();
    xfer(0, 1, 1, 32'h200, 3, 2);
    expect_rsp("R2 excl read", 1, 1, 0, 0);
    xfer(1, 1, 1, 32'h200, 3, 2);
    expect_rsp("R3 excl write wins", 1, 1, 0, 0);
    xfer(1, 1, 1, 32'h200, 3, 2);
    expect_rsp("R7 repeat write", 1, 0, 1, 0);
  endtask

  task automatic t_harmless();
    xfer(0, 1, 2, 32'h300, 3, 2);
    xfer(0, 0, 0, 32'h300, 3, 2);
    expect_rsp("R12 normal read", 0, 0, 0, 0);
    xfer(0, 1, 3, 32'h300, 0, 2);
    xfer(1, 0, 3, 32'h1000, 7, 2);
    expect_rsp("R12 normal write", 3, 0, 0, 0);
    xfer(1, 1, 2, 32'h300, 3, 2);
    expect_rsp("R4 survives foreign reads and far write", 2, 1, 0, 0);
  endtask

  task automatic t_conflict();
    xfer(0, 1, 0, 32'h400, 3, 2);
    xfer(1, 0, 1, 32'h420, 0, 2);
    xfer(1, 1, 0, 32'h400, 3, 2);
    expect_rsp("R10 same-granule write clears", 0, 0, 1, 0);
    xfer(0, 1, 1, 32'h500, 0, 2);
    xfer(0, 1, 2, 32'h500, 0, 2);
    xfer(1, 1, 1, 32'h500, 0, 2);
    expect_rsp("R5 first winner", 1, 1, 0, 0);
    xfer(1, 1, 2, 32'h500, 0, 2);
    expect_rsp("R5 loser after foreign win", 2, 0, 1, 0);
  endtask

  task automatic t_mismatch();
    xfer(0, 1, 3, 32'h600, 1, 2);
    xfer(1, 1, 3, 32'h604, 1, 2);
    expect_rsp("R6 address mismatch", 3, 0, 1, 0);
    xfer(0, 1, 3, 32'h600, 1, 2);
    xfer(1, 1, 3, 32'h600, 2, 2);
    expect_rsp("R6 length mismatch", 3, 0, 1, 0);
  endtask

  task automatic t_replace();
    xfer(0, 1, 0, 32'h700, 0, 2);
    xfer(0, 1, 0, 32'h800, 0, 2);
    xfer(1, 1, 0, 32'h700, 0, 2);
    expect_rsp("R8 old entry replaced", 0, 0, 1, 0);
    xfer(0, 1, 0, 32'h700, 0, 2);
    xfer(0, 1, 0, 32'h800, 0, 2);
    xfer(1, 1, 0, 32'h800, 0, 2);
    expect_rsp("R8 new entry wins", 0, 1, 0, 0);
  endtask

  task automatic t_proto();
    xfer(0, 1, 1, 32'h900, 16, 2);
    expect_rsp("R9 long excl read", 1, 0, 0, 1);
    xfer(1, 1, 1, 32'h900, 16, 2);
    expect_rsp("R9 long excl write", 1, 0, 1, 1);
    xfer(1, 0, 1, 32'hA00, 20, 2);
    expect_rsp("R9 long normal write", 1, 0, 0, 0);
    xfer(0, 1, 1, 32'h900, 15, 2);
    expect_rsp("R9 sixteen beats ok", 1, 1, 0, 0);
  endtask

  task automatic t_stall();
    @(negedge clk);
    rsp_ready = 1'b0;
    req_write = 0; req_excl = 0; req_id = 2; req_addr = 32'hB00;
    req_len = 0; req_size = 2; req_valid = 1'b1;
    @(negedge clk);
    req_id = 3;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R11 ready low in stall", req_ready, 0);
      chk("R11 id held", rsp_id, 2);
      chk("R11 valid held", rsp_valid, 1);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 next response", rsp_id, 3);
    chk("R11 next valid", rsp_valid, 1);
    @(negedge clk);
    chk("R11 drained", rsp_valid, 0);
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_harmless();
    t_conflict();
    t_mismatch();
    t_replace();
    t_proto();
    t_stall();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule